// File: doc/BRIEF.md
# Multiply-High Integer Execution Unit

This unit executes one integer operation: the upper half of a double-width product. It accepts a 32-bit instruction word and two XLEN-bit source values. The word is decoded as either the signed or the unsigned multiply-high operation. The unit then forms the full 2*XLEN-bit product over several cycles and returns only its upper XLEN bits, together with the destination register index taken from the word. When the record bit is set, it also returns a 4-bit condition field. Words that are not one of the two multiply-high encodings are flagged as illegal and produce no result.

Work enters through a valid/ready pair. `in_ready` is high only while the unit is idle, so a producer holding `in_valid` high simply stalls until the running operation finishes. A transfer happens on a rising edge where both `in_valid` and `in_ready` are high. Results leave as a one-cycle `done` strobe with no back-pressure: a consumer must take `result`, `dest_idx` and the condition field in the cycle `done` is high. The register file, the XER storage, the low-half multiply and the pipeline around the unit live elsewhere.

Top module: `mulhi_unit`

## Requirements
- R1: A word is legal when bits [31:26] equal 31 and bits [9:1] equal 73 (signed) or 9 (unsigned). The base signed word is 0x7C000092 and the base unsigned word is 0x7C000012.
- R2: For extended opcode 73, both operands are sign-extended to 2*XLEN bits, and `result` is bits [2*XLEN-1:XLEN] of their product.
- R3: For extended opcode 9, both operands are zero-extended, and `result` is bits [2*XLEN-1:XLEN] of their product.
- R4: `dest_idx` equals instruction bits [25:21] of the operation whose `done` is high.
- R5: When bit 0 (Rc) is 1, `cr_valid` is high together with `done`. `cr_field` is {LT,GT,EQ,SO} in bits 3..0. Exactly one of LT, GT and EQ is set: LT when `result` is negative as a signed number, EQ when it is exactly zero, and GT otherwise.
- R6: `cr_field` bit 0 equals the `xer_so` value sampled on the accepting edge.
- R7: When Rc is 0, `cr_valid` stays low for that operation.
- R8: An accepted illegal word raises `illegal` for exactly the one cycle after the accepting edge. It produces no `done` and no `cr_valid`, and `result` keeps its previous value.
- R9: `in_ready` is high only while idle. `in_valid` asserted while the unit is busy has no effect: it does not change the running result and it does not cause an extra `done`.
- R10: `done` is high for exactly one cycle, XLEN/DIGIT_BITS + 1 rising edges after the accepting edge.
- R11: After reset, `done`, `cr_valid` and `illegal` are low, `in_ready` is high, and `result` is zero.
- R12: Bit 10 (the overflow-enable position) is ignored. A legal word with that bit set gives the same result and condition field as the same word with it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle and able to accept |
| instr | input | 32 | Instruction word |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand |
| xer_so | input | 1 | Incoming summary-overflow bit |
| done | output | 1 | One-cycle result strobe |
| result | output | XLEN | Upper half of the product |
| dest_idx | output | 5 | Destination register index |
| cr_valid | output | 1 | Condition field valid (record form) |
| cr_field | output | 4 | {LT,GT,EQ,SO} |
| illegal | output | 1 | Rejected instruction word |

## Verification
A 6-bit instance is swept over every operand pair in both signedness modes with Rc set. This covers each sign combination, the most negative value on either side and the zero operands. It separates correct sign extension from zero extension, and it separates the negation carry out of the low half from a plain inversion. The 64-bit instance is run on the corner operands: the most negative value squared, -1 × -1, -1 × 1 and the largest positive value squared. Each is tried in both modes, and these cases separate signed results from unsigned ones where they differ most. Directed cases then flip Rc and the overflow-enable bit, offer operations while the unit is busy, and send wrong primary and extended opcodes, to show that each of these changes only what it should.

// File: rtl/mulhi_pkg.sv
package mulhi_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam logic [5:0]  PRIMARY_OP = 6'd31;
  localparam logic [8:0]  XO_HIGH_SIGNED = 9'd73;
  localparam logic [8:0]  XO_HIGH_UNSIGNED = 9'd9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FINISH
  } mh_state_e;

  typedef struct packed {
    logic       legal;
    logic       is_signed;
    logic       rc;
    logic [4:0] rt;
  } mh_decode_t;

endpackage

// File: rtl/mulhi_decode.sv
module mulhi_decode
  import mulhi_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output mh_decode_t         dec
);
  logic [5:0] primary;
  logic [8:0] xo;
  logic       unused_fields;

  // Big-endian numbering: bit 0 of the word is instr[31].
  assign primary = instr[31:26];
  assign xo      = instr[9:1];
  // Source fields and the overflow-enable position play no part here.
  assign unused_fields = ^instr[20:10];

  always_comb begin
    dec.is_signed = (xo == XO_HIGH_SIGNED);
    dec.legal     = (primary == PRIMARY_OP) &&
                    ((xo == XO_HIGH_SIGNED) || (xo == XO_HIGH_UNSIGNED));
    dec.rc        = instr[0];
    dec.rt        = instr[25:21];
  end
endmodule

// File: rtl/mulhi_core.sv
module mulhi_core #(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned DIGIT_BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic            is_signed,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            last_step,
  output logic [XLEN-1:0] high_out
);
  localparam int unsigned STEPS = XLEN / DIGIT_BITS;
  localparam int unsigned AW    = XLEN + DIGIT_BITS;
  localparam int unsigned CW    = $clog2(STEPS + 1);

  logic [XLEN-1:0] mcand_q;
  logic [XLEN-1:0] acc_q;
  logic [XLEN-1:0] low_q;
  logic            neg_q;
  logic [CW-1:0]   count_q;

  logic [XLEN-1:0] mag_a, mag_b;
  logic [AW-1:0]   terms [DIGIT_BITS];
  logic [AW-1:0]   pp;
  logic [AW-1:0]   sum;

  assign mag_a = (is_signed && op_a[XLEN-1]) ? (~op_a + 1'b1) : op_a;
  assign mag_b = (is_signed && op_b[XLEN-1]) ? (~op_b + 1'b1) : op_b;

  // One shifted copy of the multiplicand per bit of the current digit.
  for (genvar g = 0; g < DIGIT_BITS; g++) begin : g_term
    assign terms[g] = low_q[g] ? ({{DIGIT_BITS{1'b0}}, mcand_q} << g) : '0;
  end

  always_comb begin
    pp = '0;
    for (int i = 0; i < DIGIT_BITS; i++) pp = pp + terms[i];
    sum = {{DIGIT_BITS{1'b0}}, acc_q} + pp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
      low_q   <= '0;
      neg_q   <= 1'b0;
      count_q <= '0;
    end else if (load) begin
      mcand_q <= mag_a;
      acc_q   <= '0;
      low_q   <= mag_b;
      neg_q   <= is_signed && (op_a[XLEN-1] ^ op_b[XLEN-1]);
      count_q <= '0;
    end else if (step) begin
      acc_q   <= sum[AW-1:DIGIT_BITS];
      low_q   <= {sum[DIGIT_BITS-1:0], low_q[XLEN-1:DIGIT_BITS]};
      count_q <= count_q + 1'b1;
    end
  end

  assign last_step = (count_q == CW'(STEPS - 1));

  // Negating the 2*XLEN product: the +1 reaches the upper half only when
  // the lower half is all zero.
  assign high_out = neg_q ? (~acc_q + {{(XLEN-1){1'b0}}, (low_q == '0)}) : acc_q;

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (count_q < CW'(STEPS))) else $error("step beyond digit count"); // R10

endmodule

// File: rtl/mulhi_crgen.sv
module mulhi_crgen #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  input  logic            so_in,
  output logic [3:0]      cr
);
  always_comb begin
    if (value[XLEN-1])     cr = {3'b100, so_in};
    else if (value == '0)  cr = {3'b001, so_in};
    else                   cr = {3'b010, so_in};
  end
endmodule

// File: rtl/mulhi_unit.sv
module mulhi_unit
  import mulhi_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned DIGIT_BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            xer_so,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic [4:0]      dest_idx,
  output logic            cr_valid,
  output logic [3:0]      cr_field,
  output logic            illegal
);
  mh_state_e       state_q;
  mh_decode_t      dec, op_q;
  logic            so_q;
  logic            accept, last_step;
  logic [XLEN-1:0] high;
  logic [3:0]      cr_next;
  logic            done_q, cr_valid_q, illegal_q;
  logic [XLEN-1:0] result_q;
  logic [4:0]      dest_q;
  logic [3:0]      cr_q;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  mulhi_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  mulhi_core #(.XLEN(XLEN), .DIGIT_BITS(DIGIT_BITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && dec.legal),
    .step      (state_q == ST_RUN),
    .is_signed (dec.is_signed),
    .op_a      (src_a),
    .op_b      (src_b),
    .last_step (last_step),
    .high_out  (high)
  );

  mulhi_crgen #(.XLEN(XLEN)) u_cr (
    .value (high),
    .so_in (so_q),
    .cr    (cr_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= '0;
      so_q       <= 1'b0;
      done_q     <= 1'b0;
      cr_valid_q <= 1'b0;
      illegal_q  <= 1'b0;
      result_q   <= '0;
      dest_q     <= '0;
      cr_q       <= '0;
    end else begin
      done_q     <= 1'b0;
      cr_valid_q <= 1'b0;
      illegal_q  <= accept && !dec.legal;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && dec.legal) begin
            op_q    <= dec;
            so_q    <= xer_so;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last_step) state_q <= ST_FINISH;
        end
        ST_FINISH: begin
          result_q   <= high;
          dest_q     <= op_q.rt;
          cr_q       <= op_q.rc ? cr_next : '0;
          cr_valid_q <= op_q.rc;
          done_q     <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign result   = result_q;
  assign dest_idx = dest_q;
  assign cr_valid = cr_valid_q;
  assign cr_field = cr_q;
  assign illegal  = illegal_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10

  AST_CR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> done) else $error("condition field without result"); // R5

  AST_CR_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> $onehot(cr_field[3:1])) else $error("condition flags not one-hot"); // R5

  AST_CR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> (cr_field[3] == result[XLEN-1])) else $error("LT disagrees with sign"); // R5

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !cr_valid)) else $error("illegal word produced output"); // R8

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready) else $error("not ready when result leaves"); // R9

endmodule

// File: tb/mulhi_unit_test.sv
module mulhi_unit_test;
  localparam logic [31:0] W_SIGNED   = 32'h7C000092;
  localparam logic [31:0] W_UNSIGNED = 32'h7C000012;
  localparam int BIG_LAT   = 64/2 + 1;
  localparam int SMALL_LAT = 6/2 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        xer_so = 1'b0;
  logic        done, cr_valid, illegal;
  logic [63:0] result;
  logic [4:0]  dest_idx;
  logic [3:0]  cr_field;

  logic        s_in_valid = 1'b0;
  logic        s_in_ready;
  logic [31:0] s_instr = '0;
  logic [5:0]  s_a = '0, s_b = '0;
  logic        s_so = 1'b0;
  logic        s_done, s_cr_valid, s_illegal;
  logic [5:0]  s_result;
  logic [4:0]  s_dest;
  logic [3:0]  s_cr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  mulhi_unit #(.XLEN(64), .DIGIT_BITS(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .src_a(src_a), .src_b(src_b), .xer_so(xer_so),
    .done(done), .result(result), .dest_idx(dest_idx), .cr_valid(cr_valid),
    .cr_field(cr_field), .illegal(illegal)
  );

  mulhi_unit #(.XLEN(6), .DIGIT_BITS(2)) uut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
    .instr(s_instr), .src_a(s_a), .src_b(s_b), .xer_so(s_so),
    .done(s_done), .result(s_result), .dest_idx(s_dest), .cr_valid(s_cr_valid),
    .cr_field(s_cr), .illegal(s_illegal)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cr(input logic neg, input logic zero, input logic so);
    if (neg)       return {3'b100, so};
    else if (zero) return {3'b001, so};
    else           return {3'b010, so};
  endfunction

  // Full 64-bit operation with every output checked.
  task automatic run_big(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                         input logic so);
    logic         sgn;
    logic [127:0] ea, eb, p;
    logic [63:0]  eh;
    int           cnt;
    sgn = (w[9:1] == 9'd73);
    ea  = sgn ? {{64{a[63]}}, a} : {64'b0, a};
    eb  = sgn ? {{64{b[63]}}, b} : {64'b0, b};
    p   = ea * eb;
    eh  = p[127:64];
    @(negedge clk);
    chk("R9 ready while idle", in_ready, 1);
    instr = w; src_a = a; src_b = b; xer_so = so; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; xer_so = ~so;
    cnt = 0;
    while (!done && cnt < 100) begin @(negedge clk); cnt++; end
    chk("R10 latency", cnt, BIG_LAT);
    chk(sgn ? "R2 signed high half" : "R3 unsigned high half", result, eh);
    chk("R4 destination index", dest_idx, w[25:21]);
    if (w[0]) begin
      chk("R5 cr_valid with Rc=1", cr_valid, 1);
      chk("R5 R6 condition field", cr_field, exp_cr(eh[63], eh == 0, so));
    end else begin
      chk("R7 no cr_valid with Rc=0", cr_valid, 0);
    end
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
  endtask

  task automatic run_small(input logic [31:0] w, input logic [5:0] a, input logic [5:0] b,
                           input logic so);
    logic        sgn;
    logic [11:0] ea, eb, p;
    logic [5:0]  eh;
    int          cnt;
    sgn = (w[9:1] == 9'd73);
    ea  = sgn ? {{6{a[5]}}, a} : {6'b0, a};
    eb  = sgn ? {{6{b[5]}}, b} : {6'b0, b};
    p   = ea * eb;
    eh  = p[11:6];
    @(negedge clk);
    s_instr = w; s_a = a; s_b = b; s_so = so; s_in_valid = 1'b1;
    @(negedge clk);
    s_in_valid = 1'b0;
    cnt = 0;
    while (!s_done && cnt < 50) begin @(negedge clk); cnt++; end
    if (cnt != SMALL_LAT) chk("R10 small latency", cnt, SMALL_LAT);
    chk(sgn ? "R2 sweep" : "R3 sweep", s_result, eh);
    chk("R5 R6 sweep condition", {s_cr_valid, s_cr}, {1'b1, exp_cr(eh[5], eh == 0, so)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    int          extra;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done low", done, 0);
    chk("R11 cr_valid low", cr_valid, 0);
    chk("R11 illegal low", illegal, 0);
    chk("R11 in_ready high", in_ready, 1);
    chk("R11 result zero", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 corner operands, both modes, both Rc settings
    for (int m = 0; m < 2; m++) begin
      for (int rc = 0; rc < 2; rc++) begin
        logic [31:0] w;
        w = (m == 0 ? W_SIGNED : W_UNSIGNED) | 32'(rc) | (32'(5 + m + 2*rc) << 21);
        run_big(w, 64'h8000000000000000, 64'h8000000000000000, 1'b0);
        run_big(w, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1'b1);
        run_big(w, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 1'b0);
        run_big(w, 64'h7FFFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFFFF, 1'b1);
        run_big(w, 64'h0000000000000000, 64'h8000000000000001, 1'b1);
        run_big(w, 64'h123456789ABCDEF0, 64'hFEDCBA9876543210, 1'b0);
      end
    end

    // R12 overflow-enable bit ignored
    run_big(W_SIGNED | 32'h400 | 32'h1, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000003, 1'b0);
    run_big(W_UNSIGNED | 32'h400 | 32'h1, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1'b1);

    // R9 offers while busy are ignored
    @(negedge clk);
    instr = W_UNSIGNED | (32'd9 << 21); src_a = 64'hFFFFFFFFFFFFFFFF; src_b = 64'h10;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R9 not ready while busy", in_ready, 0);
    instr = W_SIGNED | 32'h1 | (32'd3 << 21); src_a = 64'h5; src_b = 64'h7;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    extra = 0;
    for (int k = 0; k < 60; k++) begin
      if (done) begin
        extra++;
        if (extra == 1) begin
          chk("R9 busy offer left result alone", result, 64'hF);
          chk("R9 busy offer left index alone", dest_idx, 5'd9);
        end
      end
      @(negedge clk);
    end
    chk("R9 exactly one done", extra, 1);

    // R8 illegal words: wrong primary opcode, then wrong extended opcode
    held = result;
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      instr = (t == 0) ? (W_SIGNED & ~(32'h1 << 26)) | 32'h1 : (W_SIGNED & ~32'h3FE) | (32'd233 << 1);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 illegal raised", illegal, 1);
      extra = 0;
      @(negedge clk);
      chk("R8 illegal one cycle", illegal, 0);
      for (int k = 0; k < 40; k++) begin
        if (done || cr_valid) extra++;
        @(negedge clk);
      end
      chk("R8 no done after illegal", extra, 0);
      chk("R8 result unchanged", result, held);
    end

    // R2 R3 R5 R6 exhaustive sweep on the 6-bit instance
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        run_small(W_SIGNED | 32'h1, 6'(a), 6'(b), 1'(a ^ b));
        run_small(W_UNSIGNED | 32'h1, 6'(a), 6'(b), 1'(a + b));
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule